// File: doc/BRIEF.md
# Two-Wire Serial Controller Register Front End

This block holds the software-visible registers of a two-wire serial controller. A simple CPU register bus with a 2-bit address, a write strobe and combinational read data connects on one side. A separate bus engine connects on the other side and runs the line protocol. The front end stores the control bits, the prescaler select and the data byte. It passes start, stop and enable requests to the engine. It records the engine's completion events as an interrupt flag and the engine's 5-bit status code.

Software starts a transfer by setting the enable bit and then a start or stop request. It then waits for the interrupt flag and reads the status code. Data-byte writes are checked against the flag: a write made while the engine still owns the byte is refused, and a sticky collision bit is raised. Stop requests clear themselves once the engine reports that the stop has finished. Start requests remain set until software clears them.

Register addresses: 0 control, 1 status, 2 data, 3 unused. Control layout: bit 7 interrupt flag, bit 6 reserved, bit 5 start, bit 4 stop, bit 3 collision, bit 2 enable, bit 1 reserved, bit 0 interrupt enable.

Top module: `twif_regs`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0xF8 (code field all ones, prescaler 00), the data register reads 0x00, and irq_o is 0.
- R2: The interrupt flag (control bit 7) sets on the clock edge that samples an eng_event_i pulse. It clears when software writes the control register with bit 7 = 1. If both happen in the same cycle, the set wins.
- R3: The start bit (control bit 5) follows the value that software writes to it. The hardware never clears it, including when an engine event arrives.
- R4: Writing 1 to the stop bit (control bit 4) sets it, and writing 0 has no effect on it. An eng_stop_done_i pulse clears it at that edge. A write of 1 in the same cycle as the pulse wins.
- R5: A data-register write made while the interrupt flag is 0 sets the collision bit (control bit 3) and leaves the stored byte unchanged.
- R6: A data-register write made while the interrupt flag is 1 stores the byte, drives it on eng_data_o, and clears the collision bit.
- R7: Control bits 6 and 1 always read 0. Writing the control register never changes the collision bit.
- R8: eng_en_o follows the enable bit. While enable is 0, eng_start_o and eng_stop_o are 0 whatever the start and stop bits hold.
- R9: On an eng_event_i pulse, eng_status_i is loaded into status bits 7..3. Status bit 2 reads 0. Bits 1..0 are the read/write prescaler, driven on eng_presc_o. Writes to status bits 7..2 are ignored.
- R10: irq_o is 1 exactly when the interrupt flag, the interrupt-enable bit (control bit 0) and gie_i are all 1.
- R11: Reads from address 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational from addr_i) |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| eng_event_i | input | 1 | Engine completion pulse, sets the flag and loads the status code |
| eng_status_i | input | 5 | Engine status code |
| eng_stop_done_i | input | 1 | Engine pulse: the stop condition has finished |
| eng_en_o | output | 1 | Enable to the engine |
| eng_start_o | output | 1 | Start request, gated by enable |
| eng_stop_o | output | 1 | Stop request, gated by enable |
| eng_presc_o | output | 2 | Prescaler select |
| eng_data_o | output | 8 | Stored data byte |

## Verification
The hardest cases to reach are collisions between hardware and software on the same edge. One is an engine completion arriving in the cycle that software clears the flag. The other is a stop-done pulse arriving in the cycle that software writes a new stop request. The directed tests drive both inputs on the same falling edge, so that a single rising edge samples them together, and then read the control register back to see which side won. The sticky collision bit is reached by writing the data register before any engine event has set the flag. A later control write with bit 3 at 0 then shows that software cannot clear the bit through the control register.

// File: rtl/twif_pkg.sv
package twif_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CB_FLAG  = 7;
  localparam int unsigned CB_START = 5;
  localparam int unsigned CB_STOP  = 4;
  localparam int unsigned CB_WCOL  = 3;
  localparam int unsigned CB_EN    = 2;
  localparam int unsigned CB_IE    = 0;
endpackage

// File: rtl/twif_ctrl_reg.sv
module twif_ctrl_reg
  import twif_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ev_i,
  input  logic              stop_done_i,
  output logic              flag_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              en_o,
  output logic              ie_o
);
  logic flag_q, start_q, stop_q, en_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      // engine event beats software clear
      if (ev_i)                        flag_q <= 1'b1;
      else if (wr_i && wdata_i[CB_FLAG]) flag_q <= 1'b0;
      // new request beats completion
      if (wr_i && wdata_i[CB_STOP])    stop_q <= 1'b1;
      else if (stop_done_i)            stop_q <= 1'b0;
      if (wr_i) begin
        start_q <= wdata_i[CB_START];
        en_q    <= wdata_i[CB_EN];
        ie_q    <= wdata_i[CB_IE];
      end
    end
  end

  assign flag_o  = flag_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign en_o    = en_q;
  assign ie_o    = ie_q;
endmodule

// File: rtl/twif_stat_reg.sv
module twif_stat_reg #(
  parameter int unsigned STAT_W  = 5,
  parameter int unsigned PRESC_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [PRESC_W-1:0] presc_wdata_i,
  input  logic               ev_i,
  input  logic [STAT_W-1:0]  code_i,
  output logic [STAT_W-1:0]  code_o,
  output logic [PRESC_W-1:0] presc_o
);
  logic [STAT_W-1:0]  code_q;
  logic [PRESC_W-1:0] presc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '1;
      presc_q <= '0;
    end else begin
      if (ev_i) code_q  <= code_i;
      if (wr_i) presc_q <= presc_wdata_i;
    end
  end

  assign code_o  = code_q;
  assign presc_o = presc_q;
endmodule

// File: rtl/twif_data_reg.sv
module twif_data_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              flag_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              wcol_o
);
  logic [DATA_W-1:0] data_q;
  logic              wcol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      wcol_q <= 1'b0;
    end else if (wr_i) begin
      if (flag_i) begin
        data_q <= wdata_i;
        wcol_q <= 1'b0;
      end else begin
        wcol_q <= 1'b1; // byte dropped
      end
    end
  end

  assign data_o = data_q;
  assign wcol_o = wcol_q;
endmodule

// File: rtl/twif_regs.sv
module twif_regs
  import twif_pkg::*;
#(
  parameter int unsigned STAT_W  = 5,
  parameter int unsigned PRESC_W = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  addr_i,
  input  logic                        wr_en_i,
  input  logic [STAT_W+PRESC_W:0]     wdata_i,
  output logic [STAT_W+PRESC_W:0]     rdata_o,
  input  logic                        gie_i,
  output logic                        irq_o,
  input  logic                        eng_event_i,
  input  logic [STAT_W-1:0]           eng_status_i,
  input  logic                        eng_stop_done_i,
  output logic                        eng_en_o,
  output logic                        eng_start_o,
  output logic                        eng_stop_o,
  output logic [PRESC_W-1:0]          eng_presc_o,
  output logic [STAT_W+PRESC_W:0]     eng_data_o
);
  localparam int unsigned DATA_W = STAT_W + PRESC_W + 1;

  logic wr_ctrl, wr_stat, wr_data;
  logic flag_q, start_q, stop_q, en_q, ie_q, wcol_q;
  logic [STAT_W-1:0]  code_q;
  logic [PRESC_W-1:0] presc_q;
  logic [DATA_W-1:0]  data_q;

  assign wr_ctrl = wr_en_i && (reg_sel_e'(addr_i) == REG_CTRL);
  assign wr_stat = wr_en_i && (reg_sel_e'(addr_i) == REG_STAT);
  assign wr_data = wr_en_i && (reg_sel_e'(addr_i) == REG_DATA);

  twif_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(wr_ctrl), .wdata_i,
    .ev_i(eng_event_i), .stop_done_i(eng_stop_done_i),
    .flag_o(flag_q), .start_o(start_q), .stop_o(stop_q),
    .en_o(en_q), .ie_o(ie_q)
  );

  twif_stat_reg #(.STAT_W(STAT_W), .PRESC_W(PRESC_W)) u_stat (
    .clk_i, .rst_ni,
    .wr_i(wr_stat), .presc_wdata_i(wdata_i[PRESC_W-1:0]),
    .ev_i(eng_event_i), .code_i(eng_status_i),
    .code_o(code_q), .presc_o(presc_q)
  );

  twif_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk_i, .rst_ni,
    .wr_i(wr_data), .flag_i(flag_q), .wdata_i,
    .data_o(data_q), .wcol_o(wcol_q)
  );

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      REG_CTRL: begin
        rdata_o[CB_FLAG]  = flag_q;
        rdata_o[CB_START] = start_q;
        rdata_o[CB_STOP]  = stop_q;
        rdata_o[CB_WCOL]  = wcol_q;
        rdata_o[CB_EN]    = en_q;
        rdata_o[CB_IE]    = ie_q;
      end
      REG_STAT: rdata_o = {code_q, 1'b0, presc_q};
      REG_DATA: rdata_o = data_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o       = flag_q & ie_q & gie_i;
  assign eng_en_o    = en_q;
  assign eng_start_o = start_q & en_q;
  assign eng_stop_o  = stop_q & en_q;
  assign eng_presc_o = presc_q;
  assign eng_data_o  = data_q;
endmodule

// File: rtl/twif_regs_chk.sv
module twif_regs_chk #(
  parameter int unsigned STAT_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              gie_i,
  input logic              irq_o,
  input logic              eng_event_i,
  input logic [STAT_W-1:0] eng_status_i,
  input logic              eng_stop_done_i,
  input logic              eng_en_o,
  input logic              eng_start_o,
  input logic              eng_stop_o,
  input logic              flag_q,
  input logic              stop_q,
  input logic              ie_q,
  input logic              wcol_q,
  input logic [DATA_W-1:0] data_q,
  input logic [STAT_W-1:0] code_q
);
  a_r2_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_event_i |=> flag_q);

  a_r4_stop_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_stop_done_i && !(wr_en_i && addr_i == 2'd0 && wdata_i[4])) |=> !stop_q);

  a_r5_collision_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2 && !flag_q) |=> (wcol_q && $stable(data_q)));

  a_r6_write_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2 && flag_q) |=> (!wcol_q && data_q == $past(wdata_i)));

  a_r8_gated_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_en_o |-> !(eng_start_o || eng_stop_o));

  a_r9_code_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_event_i |=> code_q == $past(eng_status_i));

  a_r10_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_i && ie_q));
endmodule

bind twif_regs twif_regs_chk #(.STAT_W(STAT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .gie_i, .irq_o,
  .eng_event_i, .eng_status_i, .eng_stop_done_i,
  .eng_en_o, .eng_start_o, .eng_stop_o,
  .flag_q, .stop_q, .ie_q, .wcol_q, .data_q, .code_q
);

// File: tb/tb_twif_regs.sv
module tb_twif_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;
  // op: 0 write, 1 read-check, 2 engine event (data = code), 3 stop done
  localparam logic [19:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 8'h05, 8'h00}, {2'd1, 2'd0, 8'h00, 8'h05},
    {2'd0, 2'd2, 8'h3C, 8'h00}, {2'd1, 2'd0, 8'h00, 8'h0D},
    {2'd1, 2'd2, 8'h00, 8'h00}, {2'd2, 2'd0, 8'h01, 8'h00},
    {2'd1, 2'd0, 8'h00, 8'h8D}, {2'd1, 2'd1, 8'h00, 8'h08},
    {2'd0, 2'd2, 8'h3C, 8'h00}, {2'd1, 2'd2, 8'h00, 8'h3C},
    {2'd1, 2'd0, 8'h00, 8'h85}, {2'd0, 2'd1, 8'hFF, 8'h00},
    {2'd1, 2'd1, 8'h00, 8'h0B}, {2'd0, 2'd0, 8'h95, 8'h00},
    {2'd1, 2'd0, 8'h00, 8'h15}, {2'd3, 2'd0, 8'h00, 8'h00},
    {2'd1, 2'd0, 8'h00, 8'h05}, {2'd0, 2'd0, 8'h67, 8'h00},
    {2'd1, 2'd0, 8'h00, 8'h25}, {2'd1, 2'd3, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       gie = 1'b1;
  logic       irq;
  logic       ev = 1'b0;
  logic [4:0] code = '0;
  logic       sdone = 1'b0;
  logic       e_en, e_start, e_stop;
  logic [1:0] e_presc;
  logic [7:0] e_data;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twif_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .gie_i(gie), .irq_o(irq), .eng_event_i(ev),
    .eng_status_i(code), .eng_stop_done_i(sdone), .eng_en_o(e_en),
    .eng_start_o(e_start), .eng_stop_o(e_stop), .eng_presc_o(e_presc),
    .eng_data_o(e_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_ev(input logic [4:0] c);
    @(negedge clk); ev = 1'b1; code = c;
    @(negedge clk); ev = 1'b0;
  endtask

  task automatic do_sd();
    @(negedge clk); sdone = 1'b1;
    @(negedge clk); sdone = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  function automatic string req_of(input logic [1:0] a);
    case (a)
      2'd0: return "R2/R4/R5/R7 ctrl";
      2'd1: return "R9 status";
      2'd2: return "R6 data";
      default: return "R11 unused";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 ctrl reset", 2'd0, 8'h00);
    rd_chk("R1 stat reset", 2'd1, 8'hF8);
    rd_chk("R1 data reset", 2'd2, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op, a;
      logic [7:0] d, x;
      {op, a, d, x} = VEC[i];
      case (op)
        2'd0: do_wr(a, d);
        2'd1: rd_chk(req_of(a), a, x);
        2'd2: do_ev(d[4:0]);
        default: do_sd();
      endcase
    end
    chk("R6 eng_data_o", e_data, 8'h3C);
    chk("R9 eng_presc_o", {6'd0, e_presc}, 8'h03);

    // ctrl now 0x25: start, en, ie
    #1 chk("R8 start passes when enabled", {6'd0, e_en, e_start}, 8'h03);
    do_wr(2'd0, 8'h20);
    #1 chk("R8 start gated", {7'd0, e_start}, 8'h00);
    rd_chk("R3 start persists", 2'd0, 8'h20);
    do_wr(2'd0, 8'h30);
    #1 chk("R8 stop gated", {6'd0, e_en, e_stop}, 8'h00);
    // R4 writing 0 leaves stop set
    do_wr(2'd0, 8'h24);
    rd_chk("R4 stop write 0 ignored", 2'd0, 8'h34);
    chk("R4 stop passes", {7'd0, e_stop}, 8'h01);
    // R4 write 1 beats completion
    @(negedge clk); addr = 2'd0; wdata = 8'h34; wr = 1'b1; sdone = 1'b1;
    @(negedge clk); wr = 1'b0; sdone = 1'b0;
    rd_chk("R4 write wins over done", 2'd0, 8'h34);
    do_sd();
    rd_chk("R4 done clears stop", 2'd0, 8'h24);

    // R10 interrupt gating
    do_ev(5'h0A);
    #1 chk("R10 irq off with ie=0", {7'd0, irq}, 8'h00);
    rd_chk("R3 start kept after event", 2'd0, 8'hA4);
    rd_chk("R9 code loaded", 2'd1, 8'h53);
    do_wr(2'd0, 8'h25);
    #1 chk("R10 irq on", {7'd0, irq}, 8'h01);
    gie = 1'b0; #1;
    chk("R10 irq off with gie=0", {7'd0, irq}, 8'h00);
    gie = 1'b1;
    // R9 writes to code bits ignored
    do_wr(2'd1, 8'h04);
    rd_chk("R9 code bits read-only", 2'd1, 8'h50);

    // R2 set wins over clear
    @(negedge clk); addr = 2'd0; wdata = 8'h85; wr = 1'b1; ev = 1'b1; code = 5'h02;
    @(negedge clk); wr = 1'b0; ev = 1'b0;
    rd_chk("R2 event wins over clear", 2'd0, 8'h85);
    do_wr(2'd0, 8'h85);
    rd_chk("R2 clear flag", 2'd0, 8'h05);
    chk("R10 irq drops with flag", {7'd0, irq}, 8'h00);

    // R5 then R7: collision sticky against ctrl writes
    do_wr(2'd2, 8'hA5);
    rd_chk("R5 collision set", 2'd0, 8'h0D);
    rd_chk("R5 data unchanged", 2'd2, 8'h3C);
    do_wr(2'd0, 8'h05);
    rd_chk("R7 ctrl write keeps wcol", 2'd0, 8'h0D);
    do_wr(2'd0, 8'hFF);
    rd_chk("R7 reserved bits read 0", 2'd0, 8'h3D);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule